// File: doc/BRIEF.md
# Stereo Peak-Detect Limiter

This block is a two-channel digital limiter for a playback sample stream. It sits after the master volume stage and receives left and right 24-bit signed samples, each pair marked by a one-cycle valid strobe. On each channel it scales the sample by its current attenuation and tracks the peak magnitude of the result over a window of samples. At the end of each window it may raise or lower the attenuation by one 0.5 dB step.

Two programmable levels set the behaviour. When the windowed peak rises above the ceiling level, the attenuation grows at the attack rate. When the peak falls below the lower floor level, the attenuation shrinks at the release rate until the signal is back at unity gain. Between the two levels the attenuation is held, which gives hysteresis. Each channel can run on its own. In the linked mode, the louder channel drives a shared decision, so both channels are attenuated together and released only when both are quiet. The limited samples leave one cycle after they arrive, and the present attenuation of each channel is visible on its own port.

Top module: `stereo_limiter`

## Requirements
- R1: While `rst` is high, and in the cycle after it, `out_valid` is 0, `out_left`, `out_right` are 0 and both attenuation ports read 0.
- R2: While `en` is low, every accepted sample leaves unchanged on the outputs. One clock with `en` low clears both attenuations to 0, along with the window state.
- R3: A 3-bit level code c decodes to the magnitude 2^(23-c), which is 0 dB full scale for c = 0 and 6 dB lower for each further code step. A peak counts as "over" only when it is strictly greater than the ceiling level, so ceiling code 0 never triggers an attack, even for the sample -8388608. A peak counts as "under" when it is strictly less than the floor level.
- R4: The window peak is the largest magnitude of the attenuated samples since the window opened. While this peak is over the ceiling, the window closes after `atk_rate`+1 accepted samples. On closing, it adds one step to the attenuation, up to at most 96 steps (48 dB).
- R5: While the window peak is not over the ceiling, the window closes after (`rel_rate`+1)*4 accepted samples. On closing, it removes one step if the peak is under the floor and the attenuation is above 0, and otherwise holds. Every window close clears the peak and the sample count.
- R6: One attenuation step is 0.5 dB. A sample x at attenuation k leaves as floor(x * m(k mod 12) / 2^(15 + k/12)), where m is a Q15 mantissa of 10^(-(k mod 12)/40). Multiples of 12 are therefore exact arithmetic right shifts by k/12.
- R7: The attenuation stays within 0..96. It changes by at most one step per accepted sample and does not change in a cycle without `in_valid`.
- R8: With `link_en` low, each channel uses only its own peak and window state, so the two attenuations evolve independently.
- R9: With `link_en` high, both channels make their decision on the larger of the two window peaks. Both therefore attack when either channel is over the ceiling, and both release only when both channels are under the floor.
- R10: When `ramp_en` is low or `lim_ramp_off` is high, both window lengths become one sample, so each accepted sample may move the attenuation by one step.
- R11: `out_valid` follows `in_valid` by one clock. The output sample is scaled by the attenuation held before that sample was taken in, while the attenuation ports show the value after that sample's update.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Limiter enable; low gives pass-through and clears state |
| link_en | input | 1 | Shared decision for both channels |
| ramp_en | input | 1 | Soft-ramp setting shared with the volume path |
| lim_ramp_off | input | 1 | Limiter-only soft-ramp bypass |
| ceil_code | input | 3 | Ceiling level code |
| floor_code | input | 3 | Floor (cushion) level code |
| atk_rate | input | 4 | Attack window code |
| rel_rate | input | 4 | Release window code |
| in_valid | input | 1 | Sample pair strobe |
| in_left | input | 24 | Left input sample, signed |
| in_right | input | 24 | Right input sample, signed |
| out_valid | output | 1 | Output sample pair strobe |
| out_left | output | 24 | Left limited sample, signed |
| out_right | output | 24 | Right limited sample, signed |
| atten_left | output | 7 | Left attenuation in 0.5 dB steps |
| atten_right | output | 7 | Right attenuation in 0.5 dB steps |

## Verification
The link property assumes `link_en` changes only while `en` is low, so that both attenuations start equal when the link is active. The bench changes the link, rates and codes only inside a clear phase with `en` low, and it keeps the floor code at or above the ceiling code. The magnitude property assumes that attenuation never amplifies, which holds for every legal input, including the most negative sample. The bench's amplitudes keep each scaled level clear of the decoded levels by more than the mantissa rounding, so its real-valued model and the fixed-point design agree on every over/under decision.

// File: rtl/lim_pkg.sv
package lim_pkg;

    localparam int DW         = 24;
    localparam int MAG_W      = DW + 1;
    localparam int CODE_W     = 3;
    localparam int RATE_W     = 4;
    localparam int REL_SHIFT  = 2;
    localparam int CNT_W      = RATE_W + REL_SHIFT + 1;
    localparam int MAX_ATT    = 96;
    localparam int ATT_W      = $clog2(MAX_ATT + 1);
    localparam int STEPS_6DB  = 12;
    localparam int FRAC_W     = 15;
    localparam int MANT_W     = FRAC_W + 1;
    localparam int NCH        = 2;

    typedef logic signed [DW-1:0] smp_t;
    typedef logic [MAG_W-1:0]     mag_t;
    typedef logic [ATT_W-1:0]     att_t;
    typedef logic [CNT_W-1:0]     cnt_t;

    typedef struct packed {
        mag_t ceil_lvl;
        mag_t floor_lvl;
        cnt_t atk_len;
        cnt_t rel_len;
    } lim_cfg_t;

    typedef enum logic [1:0] {
        STEP_HOLD    = 2'd0,
        STEP_ATTACK  = 2'd1,
        STEP_RELEASE = 2'd2
    } step_e;

    // Q15 mantissa of 10^(-i/40), i = 0..11 (half-dB steps within 6 dB)
    function automatic logic [MANT_W-1:0] mant_q15(input logic [3:0] i);
        case (i)
            4'd0:    return 16'd32768;
            4'd1:    return 16'd30935;
            4'd2:    return 16'd29205;
            4'd3:    return 16'd27571;
            4'd4:    return 16'd26029;
            4'd5:    return 16'd24573;
            4'd6:    return 16'd23198;
            4'd7:    return 16'd21900;
            4'd8:    return 16'd20675;
            4'd9:    return 16'd19519;
            4'd10:   return 16'd18427;
            default: return 16'd17396;
        endcase
    endfunction

    function automatic mag_t code_level(input logic [CODE_W-1:0] c);
        return mag_t'(1) << (DW - 1 - int'(c));
    endfunction

    function automatic mag_t abs_mag(input smp_t s);
        logic signed [MAG_W-1:0] e;
        e = {s[DW-1], s};
        return e[MAG_W-1] ? mag_t'(-e) : mag_t'(e);
    endfunction

    function automatic mag_t mag_max(input mag_t a, input mag_t b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/lim_scale.sv
module lim_scale
    import lim_pkg::*;
(
    input  att_t att,
    input  smp_t x,
    output smp_t y
);
    localparam int PW = DW + MANT_W + 1;

    logic [3:0]              frac_idx;
    logic [ATT_W-1:0]        grp;
    logic [MANT_W-1:0]       mant;
    logic [4:0]              shamt;
    logic signed [PW-1:0]    prod;
    logic signed [PW-1:0]    shifted;

    always_comb begin
        frac_idx = 4'(att % att_t'(STEPS_6DB));
        grp      = att / att_t'(STEPS_6DB);
        mant     = mant_q15(frac_idx);
        shamt    = 5'(FRAC_W) + 5'(grp);
        prod     = PW'(x) * PW'($signed({1'b0, mant}));
        shifted  = prod >>> shamt;
        y        = shifted[DW-1:0];
    end

endmodule

// File: rtl/lim_ctl.sv
module lim_ctl
    import lim_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     en,
    input  logic     valid,
    input  lim_cfg_t cfg,
    input  mag_t     peak_sel,
    output att_t     att,
    output mag_t     peak_q
);
    cnt_t  cnt_q;
    cnt_t  cnt_next;
    cnt_t  win_len;
    logic  over;
    logic  under;
    logic  win_close;
    step_e step;

    always_comb begin
        over      = peak_sel > cfg.ceil_lvl;
        under     = peak_sel < cfg.floor_lvl;
        win_len   = over ? cfg.atk_len : cfg.rel_len;
        cnt_next  = cnt_q + cnt_t'(1);
        win_close = cnt_next >= win_len;
        if (over && (att < att_t'(MAX_ATT)))
            step = STEP_ATTACK;
        else if (!over && under && (att != '0))
            step = STEP_RELEASE;
        else
            step = STEP_HOLD;
    end

    always_ff @(posedge clk) begin
        if (rst || !en) begin
            att    <= '0;
            cnt_q  <= '0;
            peak_q <= '0;
        end else if (valid) begin
            if (win_close) begin
                case (step)
                    STEP_ATTACK:  att <= att + att_t'(1);
                    STEP_RELEASE: att <= att - att_t'(1);
                    default:      att <= att;
                endcase
                cnt_q  <= '0;
                peak_q <= '0;
            end else begin
                cnt_q  <= cnt_next;
                peak_q <= peak_sel;
            end
        end
    end

endmodule

// File: rtl/stereo_limiter.sv
module stereo_limiter
    import lim_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              en,
    input  logic              link_en,
    input  logic              ramp_en,
    input  logic              lim_ramp_off,
    input  logic [2:0]        ceil_code,
    input  logic [2:0]        floor_code,
    input  logic [3:0]        atk_rate,
    input  logic [3:0]        rel_rate,
    input  logic              in_valid,
    input  logic signed [23:0] in_left,
    input  logic signed [23:0] in_right,
    output logic              out_valid,
    output logic signed [23:0] out_left,
    output logic signed [23:0] out_right,
    output logic [6:0]        atten_left,
    output logic [6:0]        atten_right
);
    lim_cfg_t cfg;
    logic     ramp_act;
    smp_t     x_c    [NCH];
    smp_t     y_c    [NCH];
    att_t     att_c  [NCH];
    mag_t     peak_c [NCH];
    mag_t     new_pk [NCH];
    mag_t     sel_pk [NCH];
    mag_t     link_pk;

    assign ramp_act = ramp_en && !lim_ramp_off;

    always_comb begin
        cfg.ceil_lvl  = code_level(ceil_code);
        cfg.floor_lvl = code_level(floor_code);
        cfg.atk_len   = ramp_act ? (cnt_t'(atk_rate) + cnt_t'(1)) : cnt_t'(1);
        cfg.rel_len   = ramp_act ? ((cnt_t'(rel_rate) + cnt_t'(1)) << REL_SHIFT)
                                 : cnt_t'(1);
    end

    assign x_c[0] = in_left;
    assign x_c[1] = in_right;

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        lim_scale u_scale (
            .att (att_c[c]),
            .x   (x_c[c]),
            .y   (y_c[c])
        );

        assign new_pk[c] = mag_max(peak_c[c], abs_mag(y_c[c]));
        assign sel_pk[c] = link_en ? link_pk : new_pk[c];

        lim_ctl u_ctl (
            .clk      (clk),
            .rst      (rst),
            .en       (en),
            .valid    (in_valid),
            .cfg      (cfg),
            .peak_sel (sel_pk[c]),
            .att      (att_c[c]),
            .peak_q   (peak_c[c])
        );
    end

    always_comb begin
        link_pk = '0;
        for (int c = 0; c < NCH; c++)
            link_pk = mag_max(link_pk, new_pk[c]);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            out_left  <= '0;
            out_right <= '0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                out_left  <= en ? y_c[0] : in_left;
                out_right <= en ? y_c[1] : in_right;
            end
        end
    end

    assign atten_left  = att_c[0];
    assign atten_right = att_c[1];

endmodule

// File: rtl/stereo_limiter_chk.sv
module stereo_limiter_chk
    import lim_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              en,
    input logic              link_en,
    input logic              in_valid,
    input logic signed [23:0] in_left,
    input logic signed [23:0] in_right,
    input logic              out_valid,
    input logic signed [23:0] out_left,
    input logic signed [23:0] out_right,
    input logic [6:0]        atten_left,
    input logic [6:0]        atten_right
);
    logic [7:0] al_w;
    logic [7:0] ar_w;
    assign al_w = {1'b0, atten_left};
    assign ar_w = {1'b0, atten_right};

    a_r1_reset_state: assert property (@(posedge clk)
        rst |=> (!out_valid && atten_left == '0 && atten_right == '0));

    a_r7_att_bounded: assert property (@(posedge clk) disable iff (rst)
        (atten_left <= 7'(MAX_ATT)) && (atten_right <= 7'(MAX_ATT)));

    a_r7_single_step: assert property (@(posedge clk) disable iff (rst)
        en |=> ((al_w <= $past(al_w) + 8'd1) && ($past(al_w) <= al_w + 8'd1) &&
                (ar_w <= $past(ar_w) + 8'd1) && ($past(ar_w) <= ar_w + 8'd1)));

    a_r7_hold_idle: assert property (@(posedge clk) disable iff (rst)
        (en && !in_valid) |=> ($stable(atten_left) && $stable(atten_right)));

    a_r2_clear_off: assert property (@(posedge clk) disable iff (rst)
        !en |=> (atten_left == '0 && atten_right == '0));

    a_r2_pass_off: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !en) |=> (out_left == $past(in_left) && out_right == $past(in_right)));

    a_r9_link_equal: assert property (@(posedge clk) disable iff (rst)
        (en && link_en && atten_left == atten_right) |=> (atten_left == atten_right));

    a_r11_valid_lag: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);

    a_r11_no_spurious: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid);

    a_r6_no_gain: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> ((abs_mag(out_left) <= abs_mag($past(in_left))) &&
                      (abs_mag(out_right) <= abs_mag($past(in_right)))));

endmodule

bind stereo_limiter stereo_limiter_chk chk_i (
    .clk         (clk),
    .rst         (rst),
    .en          (en),
    .link_en     (link_en),
    .in_valid    (in_valid),
    .in_left     (in_left),
    .in_right    (in_right),
    .out_valid   (out_valid),
    .out_left    (out_left),
    .out_right   (out_right),
    .atten_left  (atten_left),
    .atten_right (atten_right)
);

// File: tb/stereo_limiter_tb_top.sv
module stereo_limiter_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int WDOG_CYC   = 150000;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              en = 1'b0;
    logic              link_en = 1'b0;
    logic              ramp_en = 1'b1;
    logic              lim_ramp_off = 1'b0;
    logic [2:0]        ceil_code = 3'd1;
    logic [2:0]        floor_code = 3'd2;
    logic [3:0]        atk_rate = 4'd1;
    logic [3:0]        rel_rate = 4'd0;
    logic              in_valid = 1'b0;
    logic signed [23:0] in_left = '0;
    logic signed [23:0] in_right = '0;
    logic              out_valid;
    logic signed [23:0] out_left;
    logic signed [23:0] out_right;
    logic [6:0]        atten_left;
    logic [6:0]        atten_right;

    int n_chk = 0;
    int n_bad = 0;

    int  m_att [2];
    int  m_cnt [2];
    real m_pk  [2];

    always #(CLK_PERIOD/2) clk = ~clk;

    stereo_limiter dut_i (
        .clk          (clk),
        .rst          (rst),
        .en           (en),
        .link_en      (link_en),
        .ramp_en      (ramp_en),
        .lim_ramp_off (lim_ramp_off),
        .ceil_code    (ceil_code),
        .floor_code   (floor_code),
        .atk_rate     (atk_rate),
        .rel_rate     (rel_rate),
        .in_valid     (in_valid),
        .in_left      (in_left),
        .in_right     (in_right),
        .out_valid    (out_valid),
        .out_left     (out_left),
        .out_right    (out_right),
        .atten_left   (atten_left),
        .atten_right  (atten_right)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic model_clear();
        for (int c = 0; c < 2; c++) begin
            m_att[c] = 0;
            m_cnt[c] = 0;
            m_pk[c]  = 0.0;
        end
    endtask

    // Reference behaviour taken from R3, R4, R5, R8, R9, R10
    task automatic model_step(input int xl, input int xr);
        real lvl_hi, lvl_lo, np [2], sel [2], y;
        int  alen, rlen, x [2];
        bit  ramp, over, under;
        if (!en) begin
            model_clear();
            return;
        end
        x[0] = xl; x[1] = xr;
        lvl_hi = real'(1 << (23 - int'(ceil_code)));
        lvl_lo = real'(1 << (23 - int'(floor_code)));
        ramp = ramp_en && !lim_ramp_off;
        alen = ramp ? int'(atk_rate) + 1 : 1;
        rlen = ramp ? (int'(rel_rate) + 1) * 4 : 1;
        for (int c = 0; c < 2; c++) begin
            y = real'(x[c]) * $pow(10.0, -real'(m_att[c]) / 40.0);
            if (y < 0.0) y = -y;
            np[c] = (y > m_pk[c]) ? y : m_pk[c];
        end
        for (int c = 0; c < 2; c++)
            sel[c] = link_en ? ((np[0] > np[1]) ? np[0] : np[1]) : np[c];
        for (int c = 0; c < 2; c++) begin
            over  = sel[c] > lvl_hi;
            under = sel[c] < lvl_lo;
            if (m_cnt[c] + 1 >= (over ? alen : rlen)) begin
                if (over && m_att[c] < 96) m_att[c]++;
                else if (!over && under && m_att[c] > 0) m_att[c]--;
                m_cnt[c] = 0;
                m_pk[c]  = 0.0;
            end else begin
                m_cnt[c]++;
                m_pk[c] = sel[c];
            end
        end
    endtask

    task automatic send(input int xl, input int xr, input string req);
        int ab0, ab1;
        ab0 = int'(atten_left);
        ab1 = int'(atten_right);
        @(negedge clk);
        in_left  = 24'(xl);
        in_right = 24'(xr);
        in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        model_step(xl, xr);
        chk(req, "atten_left", int'(atten_left), m_att[0]);
        chk(req, "atten_right", int'(atten_right), m_att[1]);
        chk("R11", "out_valid", int'(out_valid), 1);
        if (ab0 % 12 == 0)
            chk("R6 R11", "out_left", int'(out_left), xl >>> (ab0 / 12));
        if (ab1 % 12 == 0)
            chk("R6 R11", "out_right", int'(out_right), xr >>> (ab1 / 12));
    endtask

    task automatic clear_state();
        @(negedge clk);
        en = 1'b0;
        @(negedge clk);
        model_clear();
        en = 1'b1;
    endtask

    task automatic t_reset();
        chk("R1", "out_valid", int'(out_valid), 0);
        chk("R1", "atten_left", int'(atten_left), 0);
        chk("R1", "atten_right", int'(atten_right), 0);
        chk("R1", "out_left", int'(out_left), 0);
    endtask

    task automatic t_passthrough();
        en = 1'b0;
        model_clear();
        send(8000000, -7000000, "R2");
        send(-8388608, 8388607, "R2");
        chk("R2", "out_right", int'(out_right), 8388607);
    endtask

    task automatic t_zero_code();
        ceil_code = 3'd0; floor_code = 3'd1;
        clear_state();
        for (int i = 0; i < 6; i++) send(-8388608, -8388608, "R3");
        chk("R3", "atten_left", int'(atten_left), 0);
        chk("R3", "out_left", int'(out_left), -8388608);
    endtask

    task automatic t_attack_release();
        ceil_code = 3'd1; floor_code = 3'd2; atk_rate = 4'd1; rel_rate = 4'd0;
        clear_state();
        send(8000000, 8000000, "R4");
        chk("R4", "atten after 1 sample", int'(atten_left), 0);
        send(8000000, 8000000, "R4");
        chk("R4", "atten after 2 samples", int'(atten_left), 1);
        for (int i = 0; i < 28; i++) send(8000000, 8000000, "R4");
        chk("R4", "settled atten_left", int'(atten_left), 12);
        chk("R6", "out_left at 6 dB", int'(out_left), 4000000);
        repeat (5) @(negedge clk);
        chk("R7", "idle atten_left", int'(atten_left), 12);
        for (int i = 0; i < 60; i++) send(1000000, 1000000, "R5");
        chk("R5", "released atten_left", int'(atten_left), 0);
        chk("R5", "out_left unity", int'(out_left), 1000000);
    endtask

    task automatic t_independent();
        link_en = 1'b0;
        clear_state();
        for (int i = 0; i < 30; i++) send(8000000, 6000000, "R8");
        chk("R8", "atten_left", int'(atten_left), 12);
        chk("R8", "atten_right", int'(atten_right), 7);
        for (int i = 0; i < 60; i++) send(1000000, 6000000, "R8");
        chk("R8", "atten_left released", int'(atten_left), 0);
        chk("R8", "atten_right held", int'(atten_right), 7);
    endtask

    task automatic t_link();
        en = 1'b0;
        link_en = 1'b1;
        clear_state();
        for (int i = 0; i < 30; i++) send(8000000, 100000, "R9");
        chk("R9", "atten_right linked", int'(atten_right), 12);
        chk("R9", "out_right", int'(out_right), 50000);
        for (int i = 0; i < 20; i++) send(1000000, 6000000, "R9");
        chk("R9", "atten_left held by right", int'(atten_left), 12);
        for (int i = 0; i < 60; i++) send(1000000, 1000000, "R9");
        chk("R9", "atten_left released", int'(atten_left), 0);
        chk("R9", "atten_right released", int'(atten_right), 0);
        en = 1'b0;
        link_en = 1'b0;
    endtask

    task automatic t_ramp_bypass();
        atk_rate = 4'd3;
        lim_ramp_off = 1'b1;
        clear_state();
        for (int i = 0; i < 12; i++) send(8000000, 8000000, "R10");
        chk("R10", "atten_left fast attack", int'(atten_left), 12);
        lim_ramp_off = 1'b0;
        ramp_en = 1'b0;
        clear_state();
        for (int i = 0; i < 12; i++) send(8000000, 8000000, "R10");
        chk("R10", "atten_right ramp off", int'(atten_right), 12);
        ramp_en = 1'b1;
    endtask

    task automatic t_disable();
        @(negedge clk);
        en = 1'b0;
        @(negedge clk);
        model_clear();
        chk("R2", "atten_left cleared", int'(atten_left), 0);
        chk("R2", "atten_right cleared", int'(atten_right), 0);
        send(8000000, -8000000, "R2");
        chk("R2", "out_left pass", int'(out_left), 8000000);
    endtask

    initial begin
        repeat (WDOG_CYC) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL R11 watchdog: actual=hung expected=finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        model_clear();
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_passthrough();
        t_zero_code();
        t_attack_release();
        t_independent();
        t_link();
        t_ramp_bypass();
        t_disable();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule